// File: doc/BRIEF.md
# Display Clock Source Selector

This block holds the clock-source choices for a display subsystem. It covers the pixel-processing controller, two serial display engines (DSI 0 and DSI 1) and three LCD output channels. Each consumer runs from the functional clock or from a high-speed divider output of one of two PLLs. A requester names a target and a source in a one-cycle request. Switching to the functional clock takes effect at once. Switching to a PLL output is held back until that PLL output reports that it is running, so a multiplexer is never pointed at a dead clock.

The choices are kept in a control word whose bits drive the clock multiplexers further down the chip. A shadow copy of each selection is also kept and can be read back by target. Requests that a target cannot legally take are refused with an error pulse. Only one switch can be pending at a time. Clock gating itself is outside the block; the multiplexers appear here only as select bits.

Top module: `clk_src_sel`

## Requirements
- R1: After reset the control word is zero, every readback is 0 (functional clock), and busy, done and err are low.
- R2: Target code 0 (display controller) accepts sources 0, 1 and 2 (functional clock, PLL 1, PLL 2). The chosen code is written to control bits [9:8]. Source code 3 is illegal for every target.
- R3: Target 1 (DSI 0) drives control bit 1 and target 2 (DSI 1) drives bit 10. The bit is 1 when the engine runs from its own PLL, 1 for DSI 0 and 2 for DSI 1. DSI 0 with source 2, and DSI 1 with source 1, are illegal.
- R4: Targets 3, 4 and 5 (LCD 1, 2, 3) drive control bits 0, 12 and 19, each set to 1 when a PLL source is chosen. LCD 1 may use only PLL 1; LCD 2 and LCD 3 may use only PLL 2.
- R5: When per-LCD selection is disabled (LCD_SEL_EN = 0), requests to targets 3 to 5 are illegal, and reading back any of those targets returns the display controller's source.
- R6: A legal request for a PLL source commits only once the matching active input is high. DSI targets use pll_dsi_active[s-1]; all other targets use pll_disp_active[s-1], where s is the PLL's source code. While waiting, busy is high and the control word is unchanged. Active inputs that do not match do not complete the wait.
- R7: On a commit, the control word and the readback change at the same clock edge, and done is high for the following cycle only. A request for the functional clock, or for a PLL whose matching active input is already high, commits at the edge that accepts it, with busy staying low.
- R8: An illegal request raises err for one cycle and leaves the control word and every readback unchanged.
- R9: A request that arrives while busy is high is refused with err. The pending switch still completes normally.
- R10: rd_src returns the stored source of the target named by rd_target. Target codes 6 and 7 read 0, and requests to them are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle switch request |
| req_target | input | 3 | Target code of the request |
| req_src | input | 2 | Requested source code |
| pll_disp_active | input | 2 | Display-side divider output running, per PLL |
| pll_dsi_active | input | 2 | DSI-side divider output running, per PLL |
| rd_target | input | 3 | Target whose selection is read back |
| ctrl_reg | output | CTRL_W | Multiplexer select control word |
| rd_src | output | 2 | Source code read back for rd_target |
| busy | output | 1 | A PLL switch is waiting for its active indication |
| done | output | 1 | A switch committed at the previous edge |
| err | output | 1 | A request was refused at the previous edge |

## Verification
The hardest state to reach is a pending switch that is being held off. In that state the matching active input stays low while the other three active inputs toggle, and a second request arrives at the same time. The bench sets up this state on purpose. For each PLL request it picks a random wait length, holds only the matching indication low, and randomizes the non-matching ones. On the first wait cycle it injects an intruding request, and checks that busy holds and the control word stays still. Only then does it raise the matching indication.

// File: rtl/clk_src_sel.sv
module clk_src_sel #(
  parameter bit LCD_SEL_EN = 1'b1,
  parameter int CTRL_W     = 32,
  parameter int DISPC_LSB  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_target,
  input  logic [1:0]        req_src,
  input  logic [1:0]        pll_disp_active,
  input  logic [1:0]        pll_dsi_active,
  input  logic [2:0]        rd_target,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [1:0]        rd_src,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [2:0] T_DISPC = 3'd0;
  localparam logic [2:0] T_DSI0  = 3'd1;
  localparam logic [2:0] T_DSI1  = 3'd2;
  localparam logic [2:0] T_LCD1  = 3'd3;
  localparam logic [2:0] T_LCD2  = 3'd4;
  localparam logic [2:0] T_LCD3  = 3'd5;
  localparam int B_LCD1 = 0;
  localparam int B_DSI0 = 1;
  localparam int B_DSI1 = 10;
  localparam int B_LCD2 = 12;
  localparam int B_LCD3 = 19;

  logic [CTRL_W-1:0] ctrl_q;
  logic [1:0]        sh_q [0:5];
  logic              busy_q, done_q, err_q;
  logic [2:0]        pend_t;
  logic [1:0]        pend_s;

  function automatic logic is_legal(input logic [2:0] t, input logic [1:0] s);
    case (t)
      T_DISPC:         return s != 2'd3;
      T_DSI0, T_LCD1:  return (t == T_DSI0 || LCD_SEL_EN) && (s == 2'd0 || s == 2'd1);
      T_DSI1:          return s == 2'd0 || s == 2'd2;
      T_LCD2, T_LCD3:  return LCD_SEL_EN && (s == 2'd0 || s == 2'd2);
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic src_ready(input logic [2:0] t, input logic [1:0] s,
                                     input logic [1:0] disp_a, input logic [1:0] dsi_a);
    logic [1:0] a;
    a = (t == T_DSI0 || t == T_DSI1) ? dsi_a : disp_a;
    case (s)
      2'd0:    return 1'b1;
      2'd1:    return a[0];
      2'd2:    return a[1];
      default: return 1'b0;
    endcase
  endfunction

  wire       legal       = is_legal(req_target, req_src);
  wire       accept      = req_valid && !busy_q && legal;
  wire       ready_now   = src_ready(req_target, req_src, pll_disp_active, pll_dsi_active);
  wire       ready_pend  = src_ready(pend_t, pend_s, pll_disp_active, pll_dsi_active);
  wire       commit_now  = accept && ready_now;
  wire       commit_wait = busy_q && ready_pend;
  wire       commit      = commit_now || commit_wait;
  wire [2:0] cmt_t       = busy_q ? pend_t : req_target;
  wire [1:0] cmt_s       = busy_q ? pend_s : req_src;
  wire       cmt_bit     = cmt_s != 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < 6; i++) sh_q[i] <= 2'd0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      pend_t <= 3'd0;
      pend_s <= 2'd0;
    end else begin
      err_q  <= req_valid && (busy_q || !legal);
      done_q <= commit;
      if (accept && !ready_now) begin
        busy_q <= 1'b1;
        pend_t <= req_target;
        pend_s <= req_src;
      end else if (commit_wait) begin
        busy_q <= 1'b0;
      end
      if (commit) begin
        case (cmt_t)
          T_DISPC: begin ctrl_q[DISPC_LSB +: 2] <= cmt_s; sh_q[0] <= cmt_s; end
          T_DSI0:  begin ctrl_q[B_DSI0] <= cmt_bit; sh_q[1] <= cmt_s; end
          T_DSI1:  begin ctrl_q[B_DSI1] <= cmt_bit; sh_q[2] <= cmt_s; end
          T_LCD1:  begin ctrl_q[B_LCD1] <= cmt_bit; sh_q[3] <= cmt_s; end
          T_LCD2:  begin ctrl_q[B_LCD2] <= cmt_bit; sh_q[4] <= cmt_s; end
          T_LCD3:  begin ctrl_q[B_LCD3] <= cmt_bit; sh_q[5] <= cmt_s; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_target)
      T_DISPC, T_DSI0, T_DSI1: rd_src = sh_q[rd_target];
      T_LCD1, T_LCD2, T_LCD3:  rd_src = LCD_SEL_EN ? sh_q[rd_target] : sh_q[0];
      default:                 rd_src = 2'd0;
    endcase
  end

  assign ctrl_reg = ctrl_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;

endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk #(
  parameter int CTRL_W    = 32,
  parameter int DISPC_LSB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_reg,
  input logic              busy,
  input logic              done,
  input logic              err
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ctrl_reg == '0 && !busy && !done && !err));

  a_r7_change_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_reg) |-> done);

  a_r8_err_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !done) |-> $stable(ctrl_reg));

  a_r6_wait_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_reg));

  a_r6_done_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_dispc_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reg[DISPC_LSB +: 2] != 2'd3);

endmodule

bind clk_src_sel clk_src_sel_chk #(.CTRL_W(CTRL_W), .DISPC_LSB(DISPC_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg),
  .busy(busy), .done(done), .err(err)
);

// File: tb/clk_src_sel_tb.sv
module clk_src_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, vb = 1'b0;
  logic [2:0]  req_target = 3'd0, rd_target = 3'd0;
  logic [1:0]  req_src = 2'd0, pll_disp_active = 2'd0, pll_dsi_active = 2'd0;
  logic [31:0] ctrl_reg, ctrl_b;
  logic [1:0]  rd_src, rd_src_b;
  logic        busy, done, err, busy_b, done_b, err_b;

  int nchk = 0, nfail = 0;
  logic [31:0] exp_ctrl = '0;
  logic [1:0]  exp_sh [0:5];

  always #5 clk = ~clk;

  clk_src_sel u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .req_src(req_src), .pll_disp_active(pll_disp_active), .pll_dsi_active(pll_dsi_active),
    .rd_target(rd_target), .ctrl_reg(ctrl_reg), .rd_src(rd_src),
    .busy(busy), .done(done), .err(err));

  clk_src_sel #(.LCD_SEL_EN(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_target(req_target),
    .req_src(req_src), .pll_disp_active(pll_disp_active), .pll_dsi_active(pll_dsi_active),
    .rd_target(rd_target), .ctrl_reg(ctrl_b), .rd_src(rd_src_b),
    .busy(busy_b), .done(done_b), .err(err_b));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit legal_f(input logic [2:0] t, input logic [1:0] s, input bit lcd_en);
    case (t)
      3'd0: return s != 2'd3;
      3'd1: return s == 2'd0 || s == 2'd1;
      3'd2: return s == 2'd0 || s == 2'd2;
      3'd3: return lcd_en && (s == 2'd0 || s == 2'd1);
      3'd4, 3'd5: return lcd_en && (s == 2'd0 || s == 2'd2);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] next_ctrl(input logic [31:0] c, input logic [2:0] t, input logic [1:0] s);
    logic [31:0] n = c;
    case (t)
      3'd0: n[9:8] = s;
      3'd1: n[1]  = (s != 0);
      3'd2: n[10] = (s != 0);
      3'd3: n[0]  = (s != 0);
      3'd4: n[12] = (s != 0);
      3'd5: n[19] = (s != 0);
      default: ;
    endcase
    return n;
  endfunction

  // index into {dsi[1:0],disp[1:0]} of the active input that gates a PLL source
  function automatic int match_idx(input logic [2:0] t, input logic [1:0] s);
    return ((t == 3'd1 || t == 3'd2) ? 2 : 0) + (s == 2'd2 ? 1 : 0);
  endfunction

  task automatic set_act(input logic [3:0] a);
    pll_disp_active = a[1:0];
    pll_dsi_active  = a[3:2];
  endtask

  task automatic check_readback(input string rq);
    for (int t = 0; t < 8; t++) begin
      logic [1:0] e;
      rd_target = t[2:0];
      #1;
      e = (t < 6) ? exp_sh[t] : 2'd0;
      chk(rd_src == e, rq, {30'd0, rd_src}, {30'd0, e});
    end
  endtask

  task automatic do_req(input logic [2:0] t, input logic [1:0] s, input int waitc);
    logic [3:0] a;
    int m;
    bit lg;
    lg = legal_f(t, s, 1'b1);
    m = match_idx(t, s);
    a = 4'($urandom);
    if (s != 2'd0) a[m] = (waitc == 0);
    @(negedge clk);
    set_act(a);
    req_target = t; req_src = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!lg) begin
      chk(err && !done && !busy, "R8 illegal request refused", {29'd0, err, done, busy}, 32'h4);
      chk(ctrl_reg == exp_ctrl, "R8 word unchanged", ctrl_reg, exp_ctrl);
      check_readback("R10 readback after refusal");
    end else if (s == 2'd0 || waitc == 0) begin
      exp_ctrl = next_ctrl(exp_ctrl, t, s);
      exp_sh[t] = s;
      chk(done && !busy && !err, "R7 immediate commit", {29'd0, err, done, busy}, 32'h2);
      chk(ctrl_reg == exp_ctrl, "R7 word after commit", ctrl_reg, exp_ctrl);
      check_readback("R10 readback after commit");
    end else begin
      chk(busy && !done, "R6 waits for active", {29'd0, err, done, busy}, 32'h1);
      chk(ctrl_reg == exp_ctrl, "R6 word held while waiting", ctrl_reg, exp_ctrl);
      for (int k = 1; k < waitc; k++) begin
        a = 4'($urandom);
        a[m] = 1'b0;
        set_act(a);
        if (k == 1) begin
          req_target = 3'($urandom_range(0, 7)); req_src = 2'($urandom_range(0, 3));
          req_valid = 1'b1;
        end
        @(negedge clk);
        if (k == 1) begin
          req_valid = 1'b0;
          chk(err && busy && !done, "R9 request while busy refused", {29'd0, err, done, busy}, 32'h5);
        end else begin
          chk(busy && !done, "R6 non-matching actives ignored", {29'd0, err, done, busy}, 32'h1);
        end
        chk(ctrl_reg == exp_ctrl, "R6 word held while waiting", ctrl_reg, exp_ctrl);
      end
      a[m] = 1'b1;
      set_act(a);
      @(negedge clk);
      exp_ctrl = next_ctrl(exp_ctrl, t, s);
      exp_sh[t] = s;
      chk(done && !busy, "R6 commit on matching active", {29'd0, err, done, busy}, 32'h2);
      chk(ctrl_reg == exp_ctrl, "R7 word after wait", ctrl_reg, exp_ctrl);
      check_readback("R10 readback after wait");
      @(negedge clk);
      chk(!done, "R7 done lasts one cycle", {31'd0, done}, 32'd0);
    end
    set_act(4'd0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1DC5);
    for (int i = 0; i < 6; i++) exp_sh[i] = 2'd0;
    repeat (3) @(negedge clk);
    chk(ctrl_reg == 32'd0 && !busy && !done && !err, "R1 reset state",
        {ctrl_reg[31:3], err, done, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_readback("R1 readback after reset");

    do_req(3'd0, 2'd3, 0);   // R2 code 3 illegal
    do_req(3'd1, 2'd2, 0);   // R3 DSI 0 on PLL 2
    do_req(3'd2, 2'd1, 0);   // R3 DSI 1 on PLL 1
    do_req(3'd3, 2'd2, 0);   // R4 LCD 1 on PLL 2
    do_req(3'd4, 2'd1, 0);   // R4 LCD 2 on PLL 1
    do_req(3'd6, 2'd0, 0);   // R10 unused target
    do_req(3'd0, 2'd2, 3);   // R2 dispc to PLL 2 with wait
    do_req(3'd2, 2'd2, 4);   // R3 DSI 1 waits on DSI-side active
    do_req(3'd1, 2'd1, 0);   // R3 DSI 0 immediate
    do_req(3'd3, 2'd1, 2);   // R4 LCD 1
    do_req(3'd5, 2'd2, 0);   // R4 LCD 3 immediate
    do_req(3'd4, 2'd2, 2);   // R4 LCD 2
    do_req(3'd0, 2'd0, 0);   // R2 back to functional clock

    for (int i = 0; i < 400; i++)
      do_req(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom_range(0, 4));

    // R5: instance without per-LCD selection
    @(negedge clk);
    set_act(4'b0001);
    req_target = 3'd0; req_src = 2'd1; vb = 1'b1;
    @(negedge clk);
    vb = 1'b0;
    chk(done_b && ctrl_b[9:8] == 2'd1, "R5 dispc commit on no-LCD variant", ctrl_b, 32'h100);
    for (int t = 3; t < 6; t++) begin
      rd_target = t[2:0];
      #1;
      chk(rd_src_b == 2'd1, "R5 LCD readback follows dispc", {30'd0, rd_src_b}, 32'd1);
    end
    req_target = 3'd3; req_src = 2'd1; vb = 1'b1;
    @(negedge clk);
    vb = 1'b0;
    chk(err_b && !done_b && ctrl_b == 32'h100, "R5 LCD request refused", ctrl_b, 32'h100);
    set_act(4'd0);
    finish_run();
  end
endmodule